// File: doc/BRIEF.md
# Attitude Control Mode Manager

This block decides which of six attitude-control modes is active on a small spacecraft: detumble, safe, idle, inertial pointing, nadir pointing and target pointing. It watches a precomputed body angular-rate magnitude in unsigned fixed point, a sun-avoidance flag, a fault-detection trip and an already-validated telecommand that carries a requested mode code. From these it holds the current mode and drives enables for the magnetometers, sun sensors, star trackers, gyros, GPS receiver, magnetic torquers and reaction wheels.

Automatic moves are driven by the rate. A high rate pulls any operational mode back into detumble. A low rate lets detumble settle into safe mode. A moderate rate or sun avoidance sends safe mode back to detumble. Each of these rate conditions has to persist over several consecutive evaluation strobes before it takes effect. The fault trip forces safe mode. Telecommands are the only way to move among idle and the three pointing modes, and the only way to leave safe mode for idle. The rate trigger wins over the fault trip, and the fault trip wins over a telecommand. A telecommand that is not allowed from the current mode is dropped and flagged.

Top module: `att_mode_mgr`

## Requirements
- R1: While reset is asserted and after its release, the mode is detumble, `mode_chg` and `tc_reject` are 0, and only the magnetometer and torquer enables are 1.
- R2: `mode_oh` is always one-hot. Bit 0 is detumble, 1 is safe, 2 is idle, 3 is inertial, 4 is nadir and 5 is target. `tc_mode` uses the same numbers as codes.
- R3: `rate_mag` is in degrees per second, unsigned, with RATE_FRAC fraction bits. Each limit is floor(v·2^RATE_FRAC) for v = 0.4, 1.2 and 3.0. At the defaults these are 409, 1228 and 3072. "Below" means strictly less than the limit, and "above" means strictly greater.
- R4: In detumble, a rate below the 0.4 limit on CONFIRM consecutive evaluation strobes moves the mode to safe at the clock edge of the last of those strobes.
- R5: In safe, a rate above the 1.2 limit, or `sun_avoid` high, on CONFIRM consecutive evaluation strobes moves the mode to detumble.
- R6: In idle or any pointing mode, a rate above the 3.0 limit on CONFIRM consecutive evaluation strobes moves the mode to detumble.
- R7: An evaluation strobe on which the current mode's rate condition is false restarts the count. Cycles without a strobe neither add to the count nor clear it. Any mode change restarts the count.
- R8: `fdir_trip` moves the mode to safe at the next edge, unless a rate-triggered move happens on the same edge, in which case the rate-triggered move wins.
- R9: A telecommand is legal when it asks, from idle or a pointing mode, for a different one of idle (2), inertial (3), nadir (4) or target (5), or when it asks for idle from safe. A legal telecommand sets the mode at the next edge, unless a rate or fault move happens on that edge.
- R10: A telecommand that is not legal leaves the mode unchanged and sets `tc_reject` for exactly one cycle after the edge. This includes codes 6 and 7, any request made from detumble, and a request for the current mode. A legal telecommand that loses to a rate or fault move is not flagged.
- R11: `mode_chg` is 1 for exactly the one cycle in which `mode_oh` shows a value that differs from the one before it.
- R12: Detumble enables the magnetometers and torquers. Safe enables the magnetometers, sun sensors and torquers. Idle enables the sun sensors, star trackers, gyros and wheels. Inertial enables the star trackers, gyros and wheels. Nadir and target enable the star trackers, gyros, wheels and GPS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eval_stb | input | 1 | Rate evaluation strobe |
| rate_mag | input | RATE_W | Body rate magnitude, unsigned fixed point, in degrees per second |
| sun_avoid | input | 1 | Sun-avoidance request |
| fdir_trip | input | 1 | Fault-detection trigger |
| tc_valid | input | 1 | Telecommand present this cycle |
| tc_mode | input | 3 | Requested mode code |
| mode_oh | output | 6 | One-hot current mode |
| mode_chg | output | 1 | One-cycle mode-change pulse |
| tc_reject | output | 1 | One-cycle rejected-telecommand pulse |
| en_mgm | output | 1 | Magnetometer enable |
| en_sun | output | 1 | Sun sensor enable |
| en_str | output | 1 | Star tracker enable |
| en_gyro | output | 1 | Gyro enable |
| en_gps | output | 1 | GPS enable |
| en_mgt | output | 1 | Magnetic torquer enable |
| en_rw | output | 1 | Reaction wheel enable |

## Verification
Every result is due one clock edge after its stimulus. The mode, the change pulse and the reject pulse are all registered at the edge that samples the inputs. The enables follow the mode register with no further delay. The bench drives each input set on a falling edge and keeps a reference mode and confirmation count of its own. It then compares every output on the next falling edge, once the single rising edge in between has taken effect. Rate moves become visible only at the edge of the CONFIRM-th qualifying strobe, so threshold-boundary and count-restart sequences are checked cycle by cycle rather than at their end.

// File: rtl/att_mode_mgr.sv
module att_mode_mgr #(
  parameter int RATE_W    = 16,
  parameter int RATE_FRAC = 10,
  parameter int LO_MDPS   = 400,
  parameter int MID_MDPS  = 1200,
  parameter int HI_MDPS   = 3000,
  parameter int CONFIRM   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_stb,
  input  logic [RATE_W-1:0] rate_mag,
  input  logic              sun_avoid,
  input  logic              fdir_trip,
  input  logic              tc_valid,
  input  logic [2:0]        tc_mode,
  output logic [5:0]        mode_oh,
  output logic              mode_chg,
  output logic              tc_reject,
  output logic              en_mgm,
  output logic              en_sun,
  output logic              en_str,
  output logic              en_gyro,
  output logic              en_gps,
  output logic              en_mgt,
  output logic              en_rw
);

  localparam int CW = $clog2(CONFIRM + 1);
  localparam logic [RATE_W-1:0] LIM_LO  = RATE_W'((LO_MDPS  * (1 << RATE_FRAC)) / 1000);
  localparam logic [RATE_W-1:0] LIM_MID = RATE_W'((MID_MDPS * (1 << RATE_FRAC)) / 1000);
  localparam logic [RATE_W-1:0] LIM_HI  = RATE_W'((HI_MDPS  * (1 << RATE_FRAC)) / 1000);
  localparam logic [5:0] OH_DET  = 6'b000001;
  localparam logic [5:0] OH_SAFE = 6'b000010;
  localparam logic [5:0] OH_IDLE = 6'b000100;

  logic [5:0]    mode_q, mode_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          in_det, in_safe, in_ops;
  logic          cond, rate_fire;
  logic [5:0]    tc_oh;
  logic          tc_tgt_ops, tc_legal;

  assign in_det  = mode_q[0];
  assign in_safe = mode_q[1];
  assign in_ops  = |mode_q[5:2];

  assign cond = (in_det  & (rate_mag < LIM_LO)) |
                (in_safe & ((rate_mag > LIM_MID) | sun_avoid)) |
                (in_ops  & (rate_mag > LIM_HI));

  assign rate_fire = eval_stb & cond & (cnt_q == CW'(CONFIRM - 1));

  assign tc_oh      = (tc_mode < 3'd6) ? (6'b000001 << tc_mode) : 6'b000000;
  assign tc_tgt_ops = |tc_oh[5:2];
  assign tc_legal   = tc_valid &
                      ((in_ops & tc_tgt_ops & ~|(tc_oh & mode_q)) |
                       (in_safe & tc_oh[2]));

  always_comb begin
    if (rate_fire)      mode_d = in_det ? OH_SAFE : OH_DET;
    else if (fdir_trip) mode_d = OH_SAFE;
    else if (tc_legal)  mode_d = tc_oh;
    else                mode_d = mode_q;
  end

  always_comb begin
    if (mode_d != mode_q) cnt_d = '0;
    else if (eval_stb)    cnt_d = cond ? cnt_q + CW'(1) : '0;
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= OH_DET;
      cnt_q     <= '0;
      mode_chg  <= 1'b0;
      tc_reject <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      cnt_q     <= cnt_d;
      mode_chg  <= (mode_d != mode_q);
      tc_reject <= tc_valid & ~tc_legal;
    end
  end

  assign mode_oh = mode_q;
  assign en_mgm  = mode_q[0] | mode_q[1];
  assign en_mgt  = mode_q[0] | mode_q[1];
  assign en_sun  = mode_q[1] | mode_q[2];
  assign en_str  = in_ops;
  assign en_gyro = in_ops;
  assign en_rw   = in_ops;
  assign en_gps  = mode_q[4] | mode_q[5];

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_oh) == 1);

  p_chg_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |-> (mode_oh != $past(mode_oh)));

  p_chg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_chg |-> (mode_oh == $past(mode_oh)));

  p_fdir_safe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fdir_trip && !rate_fire) |=> mode_oh[1]);

  p_tc_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|mode_oh[5:3]) && mode_oh != $past(mode_oh)) |-> $past(tc_valid));

  p_detumble_stb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_oh[0]) |-> $past(eval_stb));

  p_reject_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tc_reject |-> $past(tc_valid));

endmodule

// File: tb/att_mode_mgr_tb.sv
module att_mode_mgr_tb;

  localparam int CONF = 3;
  localparam int LO   = (400  * 1024) / 1000;
  localparam int MID  = (1200 * 1024) / 1000;
  localparam int HI   = (3000 * 1024) / 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eval_stb = 1'b0;
  logic [15:0] rate_mag = '0;
  logic        sun_avoid = 1'b0;
  logic        fdir_trip = 1'b0;
  logic        tc_valid = 1'b0;
  logic [2:0]  tc_mode = '0;
  logic [5:0]  mode_oh;
  logic        mode_chg, tc_reject;
  logic        en_mgm, en_sun, en_str, en_gyro, en_gps, en_mgt, en_rw;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int m_mode = 0;
  int m_cnt = 0;
  bit m_chg = 0;
  bit m_rej = 0;
  string m_tag = "R1";

  always #5 clk = ~clk;

  att_mode_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .eval_stb(eval_stb), .rate_mag(rate_mag),
    .sun_avoid(sun_avoid), .fdir_trip(fdir_trip), .tc_valid(tc_valid),
    .tc_mode(tc_mode), .mode_oh(mode_oh), .mode_chg(mode_chg),
    .tc_reject(tc_reject), .en_mgm(en_mgm), .en_sun(en_sun), .en_str(en_str),
    .en_gyro(en_gyro), .en_gps(en_gps), .en_mgt(en_mgt), .en_rw(en_rw)
  );

  function automatic logic [6:0] exp_en(int m);
    // {gps, rw, gyro, str, sun, mgt, mgm}
    case (m)
      0: return 7'b0000011;
      1: return 7'b0000111;
      2: return 7'b0111100;
      3: return 7'b0111000;
      default: return 7'b1111000;
    endcase
  endfunction

  function automatic bit rate_cond(int m, int r, bit sun);
    if (m == 0) return r < LO;
    if (m == 1) return (r > MID) || sun;
    return r > HI;
  endfunction

  function automatic bit tc_ok(int m, bit v, int c);
    if (!v) return 0;
    if (m >= 2 && c >= 2 && c <= 5 && c != m) return 1;
    return (m == 1) && (c == 2);
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic compare(string tag);
    chk({tag, " mode"}, {2'b00, mode_oh}, 8'(6'b000001 << m_mode));
    chk("R11 mode_chg", {7'd0, mode_chg}, {7'd0, m_chg});
    chk("R10 tc_reject", {7'd0, tc_reject}, {7'd0, m_rej});
    chk("R12 enables", {1'b0, en_gps, en_rw, en_gyro, en_str, en_sun, en_mgt, en_mgm},
        {1'b0, exp_en(m_mode)});
  endtask

  task automatic step(bit stb, int r, bit sun, bit tcv, int tcm, bit fd, string tag);
    bit cnd, fire, legal;
    int nxt;
    eval_stb = stb; rate_mag = 16'(r); sun_avoid = sun;
    tc_valid = tcv; tc_mode = 3'(tcm); fdir_trip = fd;
    cnd   = rate_cond(m_mode, r, sun);
    fire  = stb && cnd && (m_cnt == CONF - 1);
    legal = tc_ok(m_mode, tcv, tcm);
    if (fire)       begin nxt = (m_mode == 0) ? 1 : 0; m_tag = "R4/R5/R6"; end
    else if (fd)    begin nxt = 1;                     m_tag = "R8"; end
    else if (legal) begin nxt = tcm;                   m_tag = "R9"; end
    else            begin nxt = m_mode;                m_tag = "R7"; end
    if (nxt != m_mode) m_cnt = 0;
    else if (stb)      m_cnt = cnd ? m_cnt + 1 : 0;
    m_chg  = (nxt != m_mode);
    m_rej  = tcv && !legal;
    m_mode = nxt;
    @(negedge clk);
    compare(tag.len() > 0 ? tag : m_tag);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog: got hang expected completion");
        summary();
      end
    end
  end

  initial begin
    int bucket;
    int r;
    void'($urandom(32'h5EED_0A7C));
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset");

    // R3: exactly the 0.4 limit is not below it
    for (int i = 0; i < 5; i++) step(1, LO, 0, 0, 0, 0, "R3 lo boundary");
    // R4 and R7: strobe-less cycles hold the count
    step(1, LO - 1, 0, 0, 0, 0, "R7 count1");
    step(1, LO - 1, 0, 0, 0, 0, "R7 count2");
    step(0, 0, 0, 0, 0, 0, "R7 no strobe");
    step(0, 4000, 0, 0, 0, 0, "R7 no strobe");
    step(1, LO - 1, 0, 0, 0, 0, "R4 detumble to safe");

    // R10, R9: telecommands from safe
    step(0, 0, 0, 1, 3, 0, "R10 safe to inertial");
    step(0, 0, 0, 1, 2, 0, "R9 safe to idle");
    step(0, 0, 0, 1, 4, 0, "R9 idle to nadir");
    step(0, 0, 0, 1, 4, 0, "R10 same mode");
    step(0, 0, 0, 1, 7, 0, "R10 bad code");
    step(0, 0, 0, 1, 0, 0, "R10 to detumble");
    step(0, 0, 0, 1, 5, 0, "R9 nadir to target");

    // R3 high boundary, R7 restart, R6
    for (int i = 0; i < 4; i++) step(1, HI, 0, 0, 0, 0, "R3 hi boundary");
    step(1, HI + 1, 0, 0, 0, 0, "R7 hi count");
    step(1, HI + 1, 0, 0, 0, 0, "R7 hi count");
    step(1, HI, 0, 0, 0, 0, "R7 hi clear");
    step(1, HI + 1, 0, 0, 0, 0, "R6 count");
    step(1, HI + 1, 0, 0, 0, 0, "R6 count");
    step(1, HI + 1, 0, 0, 0, 0, "R6 to detumble");
    step(0, 0, 0, 1, 2, 0, "R10 from detumble");

    // R8 and its priority against the rate trigger
    step(0, 0, 0, 0, 0, 1, "R8 fdir from detumble");
    step(1, MID, 0, 0, 0, 0, "R3 mid boundary");
    step(1, MID + 1, 0, 0, 0, 0, "R5 count");
    step(1, MID + 1, 0, 0, 0, 0, "R5 count");
    step(1, MID + 1, 0, 0, 0, 1, "R8 rate beats fdir");
    step(0, 0, 0, 0, 0, 1, "R8 fdir to safe");
    for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 0, 0, "R5 sun avoidance");
    step(0, 0, 0, 0, 0, 1, "R8 fdir");
    step(0, 0, 0, 1, 2, 0, "R9 to idle");
    step(0, 0, 0, 1, 3, 1, "R8 fdir beats tc");
    step(0, 0, 0, 1, 2, 0, "R9 to idle");
    step(0, 0, 0, 1, 3, 0, "R9 idle to inertial");

    bucket = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 16 == 0) bucket = $urandom % 4;
      case (bucket)
        0: r = $urandom % LO;
        1: r = LO + $urandom % (MID - LO + 1);
        2: r = MID + 1 + $urandom % (HI - MID);
        default: r = HI + 1 + $urandom % 2000;
      endcase
      if ($urandom % 10 == 0) begin
        case ($urandom % 3)
          0: r = LO;
          1: r = MID;
          default: r = HI;
        endcase
      end
      step($urandom % 2 == 0, r, $urandom % 20 == 0, $urandom % 5 == 0,
           $urandom % 8, $urandom % 50 == 0, "");
    end
    summary();
  end

endmodule